// File: doc/BRIEF.md
# Attack/Decay Frequency Level Controller

This block picks the clock frequency level for one clock domain of a multi-domain processor. Once per sampling interval, when the interval-end strobe arrives, it compares the occupancy of the domain's input queue with the value seen at the previous interval end. A sharp shift in occupancy triggers an attack: a jump of a programmable size in the direction of the shift. Otherwise the level decays downward by a smaller programmable amount, but only while the measured performance loss stays below a programmable threshold. If the level sits pinned at either limit for a programmable number of intervals, the block forces an attack away from that limit.

Each domain gets its own instance, and the instances share no state. The frequency level is one code per 10 MHz. The default limits are 25 (250 MHz) and 100 (1 GHz). The registered level goes to a separate transition sequencer. The occupancy figure, the performance-loss figure and all settings come from outside and are read only on the strobe cycle.

Top module: `qfreq_ad_ctrl`

## Requirements
- R1: After synchronous reset the level output equals the upper limit (100). The occupancy history and the pinned-interval count are both empty.
- R2: The level changes only at a clock edge where `iv_end` is high. Occupancy, performance loss and every setting are read only in that cycle. The new level appears on the output in the cycle after the strobe.
- R3: The first interval end after reset never attacks, however large the occupancy value. It only records the occupancy.
- R4: An attack happens when |util − previous util| is strictly greater than `cfg_dev_thr`. Rising occupancy raises the level and falling occupancy lowers it.
- R5: An attack moves the level by `cfg_react`, saturated to the range [F_MIN, F_MAX] (25..100 by default). The level never leaves that range.
- R6: With no attack and `perf_loss < cfg_perf_thr`, the level drops by `cfg_decay`, saturated at F_MIN. A decay of 0 holds the level.
- R7: With no attack and `perf_loss >= cfg_perf_thr`, the level is held. The performance gate does not block a utilisation attack.
- R8: A counter counts consecutive interval ends that leave the level at F_MIN or F_MAX. At an interval end with no utilisation attack, if the counter is at least `cfg_endstop`, a forced attack of `cfg_react` happens. It moves up from F_MIN and down from F_MAX.
- R9: `cfg_endstop` = 0 disables forced attacks.
- R10: The pinned counter clears after any attack, and at any interval end that leaves the level off both limits.
- R11: Every interval end stores the current occupancy as the new history value, including interval ends that attack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain controller clock |
| rst | input | 1 | Synchronous active-high reset |
| iv_end | input | 1 | One-cycle strobe marking the end of a sampling interval |
| util | input | UTIL_W | Queue occupancy measure for the interval just ended |
| perf_loss | input | PERF_W | Performance loss measured over the interval just ended |
| cfg_dev_thr | input | UTIL_W | Occupancy change needed for an attack (strictly exceeded) |
| cfg_react | input | LVL_W | Level step taken on an attack |
| cfg_decay | input | LVL_W | Level step taken on a decay |
| cfg_perf_thr | input | PERF_W | Performance loss at or above which decay is blocked |
| cfg_endstop | input | CNT_W | Pinned intervals before a forced attack; 0 disables |
| freq_lvl | output | LVL_W | Registered target frequency level (10 MHz per code) |

## Verification
A wrong history register shows up as a wrong attack decision at the next interval end. The bench sees a level off by the reaction step instead of the decay step one cycle after the strobe. A pinned counter that is off by one moves the forced attack one interval early or late, so the level leaves the limit at the wrong strobe. Errors in saturation or direction show up on the first attack or decay that crosses a limit. Stray updates between strobes show up as a level change in cycles with no strobe.

// File: rtl/qfreq_ad_pkg.sv
package qfreq_ad_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_DECAY = 2'd1,
    ACT_UP    = 2'd2,
    ACT_DOWN  = 2'd3
  } lvl_act_e;
endpackage

// File: rtl/qfreq_util_track.sv
module qfreq_util_track #(
  parameter int UTIL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iv_end,
  input  logic [UTIL_W-1:0] util,
  input  logic [UTIL_W-1:0] dev_thr,
  output logic              atk_hit,
  output logic              atk_up
);
  logic [UTIL_W-1:0] prev_util;
  logic              have_prev;
  logic [UTIL_W-1:0] mag;

  // history of last interval's occupancy (R11), first interval flag (R3)
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_util <= '0;
      have_prev <= 1'b0;
    end else if (iv_end) begin
      prev_util <= util;
      have_prev <= 1'b1;
    end
  end

  always_comb begin
    atk_up  = util > prev_util;
    mag     = atk_up ? (util - prev_util) : (prev_util - util);
    atk_hit = have_prev && (mag > dev_thr);
  end

  // R3: the flag is set by the first strobe after reset
  p_first_r3: assert property (@(posedge clk) disable iff (rst)
    iv_end |=> have_prev);
endmodule

// File: rtl/qfreq_endstop.sv
module qfreq_endstop #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iv_end,
  input  logic             any_atk,
  input  logic             lim_next,
  input  logic [CNT_W-1:0] cfg_endstop,
  output logic             due
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (iv_end) begin
      if (any_atk || !lim_next) cnt <= '0;
      else if (cnt != CNT_TOP)  cnt <= cnt + 1'b1;
    end
  end

  // R8, R9: forced attack pending when count reached and enabled
  assign due = (cfg_endstop != '0) && (cnt >= cfg_endstop);

  // R10: the count is empty after an attack
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (iv_end && any_atk) |=> (cnt == '0));
endmodule

// File: rtl/qfreq_level_calc.sv
module qfreq_level_calc
  import qfreq_ad_pkg::*;
#(
  parameter int F_MIN = 25,
  parameter int F_MAX = 100,
  parameter int LVL_W = 7
) (
  input  logic [LVL_W-1:0] lvl,
  input  logic             atk_hit,
  input  logic             atk_up,
  input  logic             due,
  input  logic             perf_ok,
  input  logic [LVL_W-1:0] react,
  input  logic [LVL_W-1:0] decay,
  output logic [LVL_W-1:0] lvl_next,
  output logic             any_atk,
  output logic             force_hit
);
  localparam logic [LVL_W:0]   MAX_X = (LVL_W+1)'(F_MAX);
  localparam logic [LVL_W:0]   MIN_X = (LVL_W+1)'(F_MIN);
  localparam logic [LVL_W-1:0] LMAX  = LVL_W'(F_MAX);
  localparam logic [LVL_W-1:0] LMIN  = LVL_W'(F_MIN);

  lvl_act_e         act;
  logic [LVL_W-1:0] step;
  logic [LVL_W:0]   up_sum;
  logic [LVL_W:0]   dn_floor;

  always_comb begin
    force_hit = !atk_hit && due && ((lvl == LMIN) || (lvl == LMAX));
    any_atk   = atk_hit || force_hit;
    step      = decay;
    act       = ACT_HOLD;
    if (atk_hit) begin
      step = react;
      act  = atk_up ? ACT_UP : ACT_DOWN;
    end else if (force_hit) begin
      step = react;
      act  = (lvl == LMIN) ? ACT_UP : ACT_DOWN;
    end else if (perf_ok) begin
      act  = ACT_DECAY;
    end
    up_sum   = {1'b0, lvl} + {1'b0, step};
    dn_floor = MIN_X + {1'b0, step};
    case (act)
      ACT_UP:                lvl_next = (up_sum > MAX_X) ? LMAX : up_sum[LVL_W-1:0];
      ACT_DOWN, ACT_DECAY:   lvl_next = ({1'b0, lvl} < dn_floor) ? LMIN : (lvl - step);
      default:               lvl_next = lvl;
    endcase
  end
endmodule

// File: rtl/qfreq_ad_ctrl.sv
module qfreq_ad_ctrl #(
  parameter int UTIL_W = 8,
  parameter int PERF_W = 8,
  parameter int CNT_W  = 4,
  parameter int F_MIN  = 25,
  parameter int F_MAX  = 100,
  parameter int LVL_W  = $clog2(F_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iv_end,
  input  logic [UTIL_W-1:0] util,
  input  logic [PERF_W-1:0] perf_loss,
  input  logic [UTIL_W-1:0] cfg_dev_thr,
  input  logic [LVL_W-1:0]  cfg_react,
  input  logic [LVL_W-1:0]  cfg_decay,
  input  logic [PERF_W-1:0] cfg_perf_thr,
  input  logic [CNT_W-1:0]  cfg_endstop,
  output logic [LVL_W-1:0]  freq_lvl
);
  localparam logic [LVL_W-1:0] LMAX = LVL_W'(F_MAX);
  localparam logic [LVL_W-1:0] LMIN = LVL_W'(F_MIN);

  logic             atk_hit, atk_up, due, any_atk, force_hit, perf_ok, lim_next;
  logic [LVL_W-1:0] lvl_next;

  assign perf_ok  = perf_loss < cfg_perf_thr;
  assign lim_next = (lvl_next == LMAX) || (lvl_next == LMIN);

  qfreq_util_track #(.UTIL_W(UTIL_W)) u_track (
    .clk(clk), .rst(rst), .iv_end(iv_end), .util(util),
    .dev_thr(cfg_dev_thr), .atk_hit(atk_hit), .atk_up(atk_up)
  );

  qfreq_endstop #(.CNT_W(CNT_W)) u_stop (
    .clk(clk), .rst(rst), .iv_end(iv_end), .any_atk(any_atk),
    .lim_next(lim_next), .cfg_endstop(cfg_endstop), .due(due)
  );

  qfreq_level_calc #(.F_MIN(F_MIN), .F_MAX(F_MAX), .LVL_W(LVL_W)) u_calc (
    .lvl(freq_lvl), .atk_hit(atk_hit), .atk_up(atk_up), .due(due),
    .perf_ok(perf_ok), .react(cfg_react), .decay(cfg_decay),
    .lvl_next(lvl_next), .any_atk(any_atk), .force_hit(force_hit)
  );

  // R1, R2: registered level, reset to the top of the range
  always_ff @(posedge clk) begin
    if (rst)         freq_lvl <= LMAX;
    else if (iv_end) freq_lvl <= lvl_next;
  end

  p_range_r5: assert property (@(posedge clk) disable iff (rst)
    (freq_lvl >= LMIN) && (freq_lvl <= LMAX));
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !iv_end |=> $stable(freq_lvl));
  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (iv_end && !atk_hit && !force_hit && !perf_ok) |=> $stable(freq_lvl));
  p_dir_r4: assert property (@(posedge clk) disable iff (rst)
    (iv_end && atk_hit && atk_up) |=> (freq_lvl >= $past(freq_lvl)));
endmodule

// File: tb/qfreq_ad_ctrl_tb.sv
module qfreq_ad_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       iv_end = 1'b0;
  logic [7:0] util = '0, perf_loss = '0, cfg_dev_thr = '0, cfg_perf_thr = '0;
  logic [6:0] cfg_react = '0, cfg_decay = '0;
  logic [3:0] cfg_endstop = '0;
  logic [6:0] freq_lvl;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  qfreq_ad_ctrl u_dut (
    .clk(clk), .rst(rst), .iv_end(iv_end), .util(util), .perf_loss(perf_loss),
    .cfg_dev_thr(cfg_dev_thr), .cfg_react(cfg_react), .cfg_decay(cfg_decay),
    .cfg_perf_thr(cfg_perf_thr), .cfg_endstop(cfg_endstop), .freq_lvl(freq_lvl)
  );

  // fields: util, perf, dev_thr, react, decay, perf_thr, endstop, expected level
  localparam logic [63:0] VEC [NV] = '{
    {8'd40, 8'd0,  8'd10,  8'd20, 8'd5, 8'd50, 8'd0, 8'd95},  // R3 first, R6 decay
    {8'd45, 8'd0,  8'd10,  8'd20, 8'd5, 8'd50, 8'd0, 8'd90},  // R6
    {8'd56, 8'd0,  8'd10,  8'd20, 8'd5, 8'd50, 8'd0, 8'd100}, // R4 up, R5 sat
    {8'd56, 8'd60, 8'd10,  8'd20, 8'd5, 8'd50, 8'd0, 8'd100}, // R7 hold
    {8'd56, 8'd60, 8'd10,  8'd20, 8'd5, 8'd50, 8'd0, 8'd100}, // R9 no force
    {8'd30, 8'd60, 8'd10,  8'd20, 8'd5, 8'd50, 8'd0, 8'd80},  // R4 down, R7 gate no block
    {8'd30, 8'd50, 8'd10,  8'd20, 8'd5, 8'd50, 8'd0, 8'd80},  // R7 equal, R11
    {8'd30, 8'd49, 8'd10,  8'd20, 8'd5, 8'd50, 8'd0, 8'd75},  // R6
    {8'd40, 8'd0,  8'd10,  8'd20, 8'd5, 8'd50, 8'd0, 8'd70},  // R4 equal not attack
    {8'd10, 8'd0,  8'd10,  8'd50, 8'd5, 8'd50, 8'd0, 8'd25},  // R5 floor
    {8'd10, 8'd0,  8'd10,  8'd50, 8'd5, 8'd50, 8'd0, 8'd25},  // R6 sat
    {8'd10, 8'd0,  8'd10,  8'd50, 8'd5, 8'd50, 8'd2, 8'd25},  // R8 count 2
    {8'd10, 8'd0,  8'd10,  8'd50, 8'd5, 8'd50, 8'd2, 8'd75},  // R8 forced up
    {8'd10, 8'd0,  8'd10,  8'd50, 8'd0, 8'd50, 8'd0, 8'd75},  // R6 decay 0
    {8'd50, 8'd0,  8'd10,  8'd30, 8'd0, 8'd50, 8'd1, 8'd100}, // R10 attack clears
    {8'd50, 8'd60, 8'd10,  8'd30, 8'd0, 8'd50, 8'd1, 8'd100}, // R8 count 1
    {8'd50, 8'd60, 8'd10,  8'd30, 8'd0, 8'd50, 8'd1, 8'd70},  // R8 forced down
    {8'd0,  8'd0,  8'd255, 8'd30, 8'd7, 8'd50, 8'd0, 8'd63}   // R4 big threshold
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: freq_lvl=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [63:0] v);
    @(negedge clk);
    util = v[63:56]; perf_loss = v[55:48]; cfg_dev_thr = v[47:40];
    cfg_react = v[38:32]; cfg_decay = v[30:24]; cfg_perf_thr = v[23:16];
    cfg_endstop = v[11:8];
    iv_end = 1'b1;
    @(negedge clk);
    iv_end = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check("R1 reset level", freq_lvl, 7'd100);

    // R2: inputs move without a strobe, level must not change
    util = 8'd200; cfg_dev_thr = 8'd0; cfg_react = 7'd40; cfg_decay = 7'd9;
    repeat (4) @(negedge clk);
    check("R2 no strobe", freq_lvl, 7'd100);

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i]);
      check($sformatf("vector %0d (R4..R11)", i), freq_lvl, VEC[i][6:0]);
    end

    // R1/R3: reset mid-run, then first interval never attacks
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 reset again", freq_lvl, 7'd100);
    strobe({8'd200, 8'd60, 8'd0, 8'd20, 8'd5, 8'd50, 8'd0, 8'd0});
    check("R3 first interval", freq_lvl, 7'd100);
    strobe({8'd0, 8'd60, 8'd0, 8'd20, 8'd5, 8'd50, 8'd0, 8'd0});
    check("R11 history kept, R4 attack", freq_lvl, 7'd80);
    repeat (3) @(negedge clk);
    check("R2 hold after strobe", freq_lvl, 7'd80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule